// File: doc/BRIEF.md
# System Register Access Trap Arbiter

This block decides what happens when software reads or writes a protected debug control register. It looks at the current exception level, which higher levels exist and are enabled, the halted debug state, the secure-debug-disable bit, the security state and a set of trap controls. From these it picks exactly one outcome: let the access through, raise an undefined-instruction exception, trap it to level 2, or trap it to level 3.

The decision is a strict priority chain and is purely combinational. A tie-off input selects whether a halted, secure-debug-disabled access that would trap to level 3 is made undefined before or after the level-2 check. Reads and writes follow the same chain. The only difference is which fine-grained permit bit is consulted, and a direction input selects it. Any trap carries a fixed syndrome class. The register storage is held elsewhere and only the outcome leaves this block.

Top module: `sysreg_trap_arbiter`

## Requirements
- R1: An access from exception level 0 gives outcome undefined, whatever the other inputs are.
- R2: An access from exception level 3 gives outcome allow, whatever the other inputs are.
- R3: At level 1 only, with the hypervisor level enabled, the access traps to level 2 when the top level is present with the fine-grained-trap enable at 0, or when the permit bit for the access direction is 0. At level 2 this check is never made.
- R4: A level-3 trap condition holds when the top level is present and either the secure state is in force (non-secure bit 0) with the 2-bit secure control field not equal to 2'b11, or the non-secure bit is 1 with bit 0 of that field equal to 0. At level 1 or 2, when no earlier rule applies, this condition gives trap to level 3, and otherwise the outcome is allow.
- R5: When a level-3 trap condition would be taken while halted with secure-debug-disable set, the outcome is undefined instead.
- R6: With the trap-priority tie-off at 1, a level-1 or level-2 access that is halted, has secure-debug-disable set and meets a level-3 trap condition is undefined, ranked above the level-2 trap check. With the tie-off at 0 the level-2 check ranks first.
- R7: A read (direction input 0) uses the read permit bit and a write (direction input 1) uses the write permit bit. The permit bit of the other direction has no effect.
- R8: The trap flag is 1 exactly when the outcome is a trap. The syndrome class output is 6'h18 on any trap and 0 otherwise.
- R9: The outcome is encoded as 2'b00 allow, 2'b01 undefined, 2'b10 trap to level 2, 2'b11 trap to level 3.
- R10: With the top level absent, no level-3 condition holds, and the fine-grained-trap enable term of the level-2 check is false.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| cur_level | input | 2 | Current exception level, 0 to 3 |
| top_present | input | 1 | Level 3 is implemented |
| hyp_enabled | input | 1 | Level 2 is enabled in the current security state |
| dbg_halted | input | 1 | Core is in halted debug state |
| sec_dbg_off | input | 1 | Secure-debug-disable bit |
| halt_prio_tie | input | 1 | Tie-off: halted level-3 undefined ranks above the level-2 check |
| sec_buf_ctl | input | 2 | Secure branch-buffer control field |
| non_secure | input | 1 | Non-secure state bit |
| fg_trap_en | input | 1 | Fine-grained-trap enable from level 3 |
| permit_rd | input | 1 | Fine-grained read permit (0 traps) |
| permit_wr | input | 1 | Fine-grained write permit (0 traps) |
| is_write | input | 1 | Access direction: 0 read, 1 write |
| outcome | output | 2 | Access outcome, encoded as in R9 |
| trap_valid | output | 1 | Outcome is a trap |
| trap_class | output | 6 | Syndrome class of the trap |

## Verification
Every result of this block is due in the same cycle as its stimulus: there is no register between the inputs and the outputs. The bench changes inputs one time unit after a rising clock edge. It samples the outputs at the following falling edge, half a period later, when all inputs have long settled. A vector table covers the priority orderings. It is followed by a sweep of all 16384 input combinations, each compared with a model written as a flat decision list.

// File: rtl/sysreg_trap_pkg.sv
package sysreg_trap_pkg;

  localparam int LVL_W   = 2;
  localparam int CTL_W   = 2;
  localparam int CLASS_W = 6;
  localparam logic [CLASS_W-1:0] TRAP_CLASS = 6'h18;

  typedef enum logic [1:0] {
    ACC_ALLOW    = 2'b00,
    ACC_UNDEF    = 2'b01,
    ACC_TRAP_HYP = 2'b10,
    ACC_TRAP_MON = 2'b11
  } acc_result_e;

  // Level-3 trap condition from security state and control field.
  function automatic logic mon_trap_cond(input logic present,
                                         input logic nonsec,
                                         input logic [CTL_W-1:0] ctl);
    logic secure_hit;
    logic nonsec_hit;
    secure_hit = !nonsec && (ctl != 2'b11);
    nonsec_hit = nonsec && !ctl[0];
    return present && (secure_hit || nonsec_hit);
  endfunction

  // Level-2 trap condition; caller restricts to level 1.
  function automatic logic hyp_trap_cond(input logic hyp_en,
                                         input logic present,
                                         input logic fg_en,
                                         input logic permit);
    return hyp_en && ((present && !fg_en) || !permit);
  endfunction

endpackage

// File: rtl/stg_mon_check.sv
module stg_mon_check
  import sysreg_trap_pkg::*;
(
  input  logic             top_present,
  input  logic             non_secure,
  input  logic [CTL_W-1:0] sec_buf_ctl,
  input  logic             dbg_halted,
  input  logic             sec_dbg_off,
  output logic             mon_hit,
  output logic             halt_block
);
  assign mon_hit    = mon_trap_cond(top_present, non_secure, sec_buf_ctl);
  assign halt_block = dbg_halted && sec_dbg_off;
endmodule

// File: rtl/stg_hyp_check.sv
module stg_hyp_check
  import sysreg_trap_pkg::*;
(
  input  logic             is_level1,
  input  logic             hyp_enabled,
  input  logic             top_present,
  input  logic             fg_trap_en,
  input  logic             permit_rd,
  input  logic             permit_wr,
  input  logic             is_write,
  output logic             hyp_hit
);
  logic permit_sel;

  assign permit_sel = is_write ? permit_wr : permit_rd;
  assign hyp_hit    = is_level1 &&
                      hyp_trap_cond(hyp_enabled, top_present, fg_trap_en, permit_sel);
endmodule

// File: rtl/stg_resolve.sv
module stg_resolve
  import sysreg_trap_pkg::*;
(
  input  logic [LVL_W-1:0]   cur_level,
  input  logic               halt_prio_tie,
  input  logic               mon_hit,
  input  logic               halt_block,
  input  logic               hyp_hit,
  output acc_result_e        result,
  output logic               trap_valid,
  output logic [CLASS_W-1:0] trap_class
);
  logic early_undef;

  assign early_undef = halt_prio_tie && halt_block && mon_hit;

  always_comb begin
    result = ACC_ALLOW;
    unique case (cur_level)
      2'd0: result = ACC_UNDEF;
      2'd3: result = ACC_ALLOW;
      default: begin
        if (early_undef)    result = ACC_UNDEF;
        else if (hyp_hit)   result = ACC_TRAP_HYP;
        else if (mon_hit)   result = halt_block ? ACC_UNDEF : ACC_TRAP_MON;
        else                result = ACC_ALLOW;
      end
    endcase
  end

  assign trap_valid = (result == ACC_TRAP_HYP) || (result == ACC_TRAP_MON);
  assign trap_class = trap_valid ? TRAP_CLASS : '0;
endmodule

// File: rtl/sysreg_trap_arbiter.sv
module sysreg_trap_arbiter
  import sysreg_trap_pkg::*;
(
  input  logic [1:0] cur_level,
  input  logic       top_present,
  input  logic       hyp_enabled,
  input  logic       dbg_halted,
  input  logic       sec_dbg_off,
  input  logic       halt_prio_tie,
  input  logic [1:0] sec_buf_ctl,
  input  logic       non_secure,
  input  logic       fg_trap_en,
  input  logic       permit_rd,
  input  logic       permit_wr,
  input  logic       is_write,
  output logic [1:0] outcome,
  output logic       trap_valid,
  output logic [5:0] trap_class
);
  logic        mon_hit;
  logic        halt_block;
  logic        hyp_hit;
  acc_result_e result;

  stg_mon_check u_mon (
    .top_present (top_present),
    .non_secure  (non_secure),
    .sec_buf_ctl (sec_buf_ctl),
    .dbg_halted  (dbg_halted),
    .sec_dbg_off (sec_dbg_off),
    .mon_hit     (mon_hit),
    .halt_block  (halt_block)
  );

  stg_hyp_check u_hyp (
    .is_level1   (cur_level == 2'd1),
    .hyp_enabled (hyp_enabled),
    .top_present (top_present),
    .fg_trap_en  (fg_trap_en),
    .permit_rd   (permit_rd),
    .permit_wr   (permit_wr),
    .is_write    (is_write),
    .hyp_hit     (hyp_hit)
  );

  stg_resolve u_res (
    .cur_level     (cur_level),
    .halt_prio_tie (halt_prio_tie),
    .mon_hit       (mon_hit),
    .halt_block    (halt_block),
    .hyp_hit       (hyp_hit),
    .result        (result),
    .trap_valid    (trap_valid),
    .trap_class    (trap_class)
  );

  assign outcome = result;
endmodule

// File: rtl/sysreg_trap_arbiter_chk.sv
module sysreg_trap_arbiter_chk (
  input logic [1:0] cur_level,
  input logic       top_present,
  input logic       hyp_enabled,
  input logic       dbg_halted,
  input logic       sec_dbg_off,
  input logic       halt_prio_tie,
  input logic [1:0] outcome,
  input logic       trap_valid,
  input logic [5:0] trap_class,
  input logic       mon_hit,
  input logic       hyp_hit
);
  logic mid_level;
  assign mid_level = (cur_level == 2'd1) || (cur_level == 2'd2);

  always_comb begin
    assert_el0_undef_R1: assert (cur_level != 2'd0 || outcome == 2'b01)
      else $error("level 0 access not undefined");
    assert_el3_allow_R2: assert (cur_level != 2'd3 || outcome == 2'b00)
      else $error("level 3 access not allowed");
    assert_hyp_only_l1_R3: assert (outcome != 2'b10 || (cur_level == 2'd1 && hyp_enabled))
      else $error("level-2 trap outside level 1");
    assert_hyp_taken_R3: assert (!(hyp_hit && cur_level == 2'd1) ||
                                 (halt_prio_tie && dbg_halted && sec_dbg_off && mon_hit) ||
                                 outcome == 2'b10)
      else $error("level-2 trap condition not taken");
    assert_halt_no_mon_R5: assert (outcome != 2'b11 || !(dbg_halted && sec_dbg_off))
      else $error("level-3 trap while halted with debug disabled");
    assert_early_undef_R6: assert (!(mid_level && halt_prio_tie && dbg_halted &&
                                     sec_dbg_off && mon_hit) || outcome == 2'b01)
      else $error("tie-off undefined not ranked first");
    assert_trap_flag_R8: assert (trap_valid == outcome[1])
      else $error("trap flag mismatch");
    assert_trap_class_R8: assert (trap_class == (trap_valid ? 6'h18 : 6'h00))
      else $error("syndrome class mismatch");
    assert_absent_top_R10: assert (top_present || (outcome != 2'b11 && !mon_hit))
      else $error("level-3 outcome with top level absent");
  end
endmodule

bind sysreg_trap_arbiter sysreg_trap_arbiter_chk u_chk (
  .cur_level     (cur_level),
  .top_present   (top_present),
  .hyp_enabled   (hyp_enabled),
  .dbg_halted    (dbg_halted),
  .sec_dbg_off   (sec_dbg_off),
  .halt_prio_tie (halt_prio_tie),
  .outcome       (outcome),
  .trap_valid    (trap_valid),
  .trap_class    (trap_class),
  .mon_hit       (mon_hit),
  .hyp_hit       (hyp_hit)
);

// File: tb/sysreg_trap_arbiter_tb.sv
module sysreg_trap_arbiter_tb;
  // vector: {lvl[2], pres, hyp, halt, sdd, prio, ctl[2], ns, fgt, prd, pwr, wr, exp[2]}
  localparam int NV = 17;
  localparam logic [15:0] VEC [NV] = '{
    {2'd0,1'b0,1'b0,1'b0,1'b0,1'b0,2'b00,1'b0,1'b0,1'b0,1'b0,1'b0,2'b01}, // R1
    {2'd3,1'b1,1'b1,1'b1,1'b1,1'b1,2'b00,1'b0,1'b0,1'b0,1'b0,1'b0,2'b00}, // R2
    {2'd1,1'b1,1'b1,1'b0,1'b0,1'b0,2'b11,1'b1,1'b1,1'b1,1'b0,1'b0,2'b00}, // R7 read ok
    {2'd1,1'b1,1'b1,1'b0,1'b0,1'b0,2'b11,1'b1,1'b1,1'b0,1'b1,1'b0,2'b10}, // R3 read deny
    {2'd1,1'b1,1'b1,1'b0,1'b0,1'b0,2'b11,1'b1,1'b1,1'b0,1'b1,1'b1,2'b00}, // R7 write ok
    {2'd1,1'b1,1'b1,1'b0,1'b0,1'b0,2'b11,1'b1,1'b0,1'b1,1'b1,1'b0,2'b10}, // R3 fgt off
    {2'd1,1'b1,1'b0,1'b0,1'b0,1'b0,2'b10,1'b0,1'b1,1'b1,1'b1,1'b0,2'b11}, // R4 secure
    {2'd2,1'b1,1'b1,1'b0,1'b0,1'b0,2'b10,1'b0,1'b0,1'b0,1'b0,1'b0,2'b11}, // R3 not at l2
    {2'd2,1'b1,1'b0,1'b0,1'b0,1'b0,2'b10,1'b1,1'b1,1'b1,1'b1,1'b0,2'b11}, // R4 nonsec
    {2'd2,1'b1,1'b0,1'b0,1'b0,1'b0,2'b01,1'b1,1'b1,1'b1,1'b1,1'b0,2'b00}, // R4 nonsec ok
    {2'd1,1'b1,1'b0,1'b0,1'b0,1'b0,2'b11,1'b0,1'b1,1'b1,1'b1,1'b0,2'b00}, // R4 secure ok
    {2'd1,1'b0,1'b0,1'b0,1'b0,1'b0,2'b00,1'b0,1'b0,1'b1,1'b1,1'b0,2'b00}, // R10
    {2'd1,1'b1,1'b1,1'b1,1'b1,1'b0,2'b00,1'b0,1'b0,1'b1,1'b1,1'b0,2'b10}, // R6 tie 0
    {2'd1,1'b1,1'b1,1'b1,1'b1,1'b1,2'b00,1'b0,1'b0,1'b1,1'b1,1'b0,2'b01}, // R6 tie 1
    {2'd1,1'b1,1'b0,1'b1,1'b1,1'b0,2'b00,1'b0,1'b1,1'b1,1'b1,1'b0,2'b01}, // R5
    {2'd2,1'b1,1'b0,1'b1,1'b0,1'b0,2'b00,1'b0,1'b1,1'b1,1'b1,1'b0,2'b11}, // R5 sdd low
    {2'd1,1'b0,1'b1,1'b1,1'b1,1'b1,2'b00,1'b0,1'b0,1'b0,1'b1,1'b0,2'b10}  // R10 R6
  };

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] cur_level;
  logic       top_present, hyp_enabled, dbg_halted, sec_dbg_off, halt_prio_tie;
  logic [1:0] sec_buf_ctl;
  logic       non_secure, fg_trap_en, permit_rd, permit_wr, is_write;
  logic [1:0] outcome;
  logic       trap_valid;
  logic [5:0] trap_class;
  int         checks = 0;
  int         failures = 0;
  bit         done = 1'b0;

  always #5 clk = ~clk;

  sysreg_trap_arbiter u_dut (
    .cur_level(cur_level), .top_present(top_present), .hyp_enabled(hyp_enabled),
    .dbg_halted(dbg_halted), .sec_dbg_off(sec_dbg_off), .halt_prio_tie(halt_prio_tie),
    .sec_buf_ctl(sec_buf_ctl), .non_secure(non_secure), .fg_trap_en(fg_trap_en),
    .permit_rd(permit_rd), .permit_wr(permit_wr), .is_write(is_write),
    .outcome(outcome), .trap_valid(trap_valid), .trap_class(trap_class)
  );

  // Flat decision list restating R1..R10.
  function automatic logic [1:0] model(input logic [13:0] s);
    logic [1:0] l; logic p, h, ht, sd, pr, ns, fg, rd, wr, w; logic [1:0] c;
    logic l3, l2, perm;
    {l, p, h, ht, sd, pr, c, ns, fg, rd, wr, w} = s;
    perm = w ? wr : rd;
    l3 = 1'b0;
    if (p && ns && c[0] == 1'b0) l3 = 1'b1;
    if (p && !ns && c != 2'b11)  l3 = 1'b1;
    l2 = (l == 2'd1) && h && (!perm || (p && !fg));
    if (l == 2'd0) return 2'b01;
    if (l == 2'd3) return 2'b00;
    if (pr && ht && sd && l3) return 2'b01;
    if (l2) return 2'b10;
    if (l3 && ht && sd) return 2'b01;
    if (l3) return 2'b11;
    return 2'b00;
  endfunction

  task automatic apply(input logic [13:0] s);
    @(posedge clk); #1;
    {cur_level, top_present, hyp_enabled, dbg_halted, sec_dbg_off, halt_prio_tie,
     sec_buf_ctl, non_secure, fg_trap_en, permit_rd, permit_wr, is_write} = s;
    @(negedge clk);
  endtask

  task automatic check_out(input string req, input logic [1:0] exp);
    logic [5:0] exp_cls;
    exp_cls = exp[1] ? 6'h18 : 6'h00;
    checks++;
    if (outcome !== exp || trap_valid !== exp[1] || trap_class !== exp_cls) begin
      failures++;
      $display("FAIL %s: outcome=%b valid=%b class=%h expected outcome=%b valid=%b class=%h",
               req, outcome, trap_valid, trap_class, exp, exp[1], exp_cls);
    end
  endtask

  initial begin
    #1_000_000;
    if (!done) begin
      failures++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    {cur_level, top_present, hyp_enabled, dbg_halted, sec_dbg_off, halt_prio_tie,
     sec_buf_ctl, non_secure, fg_trap_en, permit_rd, permit_wr, is_write} = '0;
    repeat (2) @(posedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check_out("R1 R9 idle all-zero", 2'b01);

    for (int i = 0; i < NV; i++) begin
      apply(VEC[i][15:2]);
      check_out("R3-table", VEC[i][1:0]);
    end

    // R7: the other direction's permit bit has no effect
    apply({2'd1,1'b1,1'b1,1'b0,1'b0,1'b0,2'b11,1'b1,1'b1,1'b1,1'b0,1'b0});
    check_out("R7 write permit ignored on read", 2'b00);
    apply({2'd1,1'b1,1'b1,1'b0,1'b0,1'b0,2'b11,1'b1,1'b1,1'b0,1'b1,1'b1});
    check_out("R7 read permit ignored on write", 2'b00);
    // R8: trap class on level-3 trap
    apply({2'd2,1'b1,1'b0,1'b0,1'b0,1'b0,2'b00,1'b0,1'b0,1'b1,1'b1,1'b0});
    check_out("R8 class on level-3 trap", 2'b11);

    // exhaustive sweep against the model
    for (int k = 0; k < 16384; k++) begin
      apply(k[13:0]);
      check_out("R4 R5 R6 R10 sweep", model(k[13:0]));
    end

    done = 1'b1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule